// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Masked Writes

This block is a single bank of up to 32 general-purpose pins, controlled through a small memory-mapped register port. Software changes output levels through two write-only half-bank registers. Each write carries a 16-bit mask in its upper half and 16 data bits in its lower half, so one pin, or any group of pins in a half, can be changed in one bus write. No read-modify-write is needed, so a concurrent update to the other pins cannot be lost.

Each pin also has a direction bit and an output-enable bit. A pin drives its output only when both bits are 1. Incoming pin levels pass through a two-flop synchronizer before they reach the read-only level register. The `BANK_IDX` parameter places the bank's registers in a shared address map, so several banks can sit on the same bus. The `NUM_PINS` parameter sets how many pins exist. In bank 0, two pins have their direction fixed to output.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every output level and every output-enable bit is 0. Every direction bit is 0 except the fixed ones. Read data is 0.
- R2: A write to the low-half register (byte offset 8*BANK_IDX) updates pin i (0..15) from write bit i only when mask bit 16+i is 0.
- R3: A write to the high-half register (byte offset 8*BANK_IDX+4) updates pin 16+j from write bit j only when mask bit 16+j is 0.
- R4: A pin whose mask bit is 1 keeps its previous output level through a half-register write.
- R5: The level register (offset 0x60+4*BANK_IDX) returns the pin inputs through two synchronizer flops. A read issued in the second cycle after an input change still returns the old value, and a read issued in the third cycle returns the new value.
- R6: The direction register (offset 0x204+0x40*BANK_IDX) is readable and writable, with bit i for pin i. A 1 selects output.
- R7: The output-enable register (offset 0x208+0x40*BANK_IDX) is readable and writable. A pin's output-enable output is 1 only when both its direction bit and its enable bit are 1.
- R8: Bit positions at or above NUM_PINS read as 0 and ignore writes, on every register and output.
- R9: When BANK_IDX is 0, direction bits 7 and 8 always read as 1, and writing 0 to them has no effect.
- R10: Read data appears in the cycle after the read strobe and is 0 in any other cycle. Reading the half-bank registers or an unmapped offset returns 0.
- R11: Writes that carry another bank's offsets leave this bank's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| pin_i | input | 32 | Asynchronous pin inputs |
| pin_o | output | 32 | Output levels |
| pin_oe_o | output | 32 | Per-pin driver enable |

## Verification
Half-register, direction and enable writes take effect at the clock edge that samples the strobe. The bench drives each strobe on a falling edge and checks the pin outputs on the next falling edge. Read data is registered, so every read is checked one falling edge after its strobe, and the following cycle is checked for 0. Pin inputs cross two synchronizer flops plus the read register. The bench therefore checks the read launched in the second cycle after an input change, which must still show the old level, and the read launched in the third cycle, which must show the new level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;

  function automatic int unsigned lo_off(int unsigned bank);
    return 8 * bank;
  endfunction

  function automatic int unsigned hi_off(int unsigned bank);
    return 8 * bank + 4;
  endfunction

  function automatic int unsigned lvl_off(int unsigned bank);
    return 32'h60 + 4 * bank;
  endfunction

  function automatic int unsigned dir_off(int unsigned bank);
    return 32'h204 + 32'h40 * bank;
  endfunction

  function automatic int unsigned oen_off(int unsigned bank);
    return 32'h208 + 32'h40 * bank;
  endfunction

  function automatic logic [REG_W-1:0] impl_mask(int unsigned num_pins);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < num_pins);
    return m;
  endfunction

  // bank 0 pins 7 and 8 are output-only
  function automatic logic [REG_W-1:0] fixed_out_mask(int unsigned bank, int unsigned num_pins);
    logic [REG_W-1:0] m;
    m = '0;
    if (bank == 0) begin
      m[7] = 1'b1;
      m[8] = 1'b1;
    end
    return m & impl_mask(num_pins);
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  out_q_o,
  output logic [REG_W-1:0]  dir_q_o,
  output logic [REG_W-1:0]  oen_q_o
);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(lo_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(hi_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(dir_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] OEN_A = ADDR_W'(oen_off(BANK_IDX));
  localparam logic [REG_W-1:0]  FIXED = fixed_out_mask(BANK_IDX, NUM_PINS);

  logic wr_lo, wr_hi, wr_dir, wr_oen;
  assign wr_lo  = wr_en_i && (addr_i == LO_A);
  assign wr_hi  = wr_en_i && (addr_i == HI_A);
  assign wr_dir = wr_en_i && (addr_i == DIR_A);
  assign wr_oen = wr_en_i && (addr_i == OEN_A);

  for (genvar i = 0; i < REG_W; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_impl
      localparam int unsigned SUB = i % HALF_W;
      logic half_hit;
      assign half_hit = (i < HALF_W) ? wr_lo : wr_hi;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          out_q_o[i] <= 1'b0;
          oen_q_o[i] <= 1'b0;
        end else begin
          if (half_hit && !wdata_i[HALF_W+SUB]) out_q_o[i] <= wdata_i[SUB];
          if (wr_oen) oen_q_o[i] <= wdata_i[i];
        end
      end

      if (FIXED[i]) begin : g_fixed
        assign dir_q_o[i] = 1'b1;
      end else begin : g_free
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)     dir_q_o[i] <= 1'b0;
          else if (wr_dir) dir_q_o[i] <= wdata_i[i];
        end
      end
    end else begin : g_absent
      assign out_q_o[i] = 1'b0;
      assign dir_q_o[i] = 1'b0;
      assign oen_q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       pin_i,
  output logic [31:0]       pin_o,
  output logic [31:0]       pin_oe_o
);
  localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(lvl_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(dir_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] OEN_A = ADDR_W'(oen_off(BANK_IDX));
  localparam logic [REG_W-1:0]  IMPL  = impl_mask(NUM_PINS);

  logic [REG_W-1:0] lvl_sync, out_q, dir_q, oen_q;

  gpio_bank_sync #(.WIDTH(REG_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lvl_sync)
  );

  gpio_bank_regs #(
    .BANK_IDX (BANK_IDX),
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .out_q_o (out_q),
    .dir_q_o (dir_q),
    .oen_q_o (oen_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        LVL_A:   rdata_o <= lvl_sync & IMPL;
        DIR_A:   rdata_o <= dir_q;
        OEN_A:   rdata_o <= oen_q;
        default: rdata_o <= '0;
      endcase
    end else begin
      rdata_o <= '0;
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q & oen_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       pin_o,
  input logic [31:0]       pin_oe_o,
  input logic [31:0]       dir_q
);
  localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(lo_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(hi_off(BANK_IDX));
  localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(dir_off(BANK_IDX));
  localparam logic [REG_W-1:0]  IMPL  = impl_mask(NUM_PINS);
  localparam logic [REG_W-1:0]  FIXED = fixed_out_mask(BANK_IDX, NUM_PINS);

  // R2
  lo_write_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == LO_A) |=>
      (((pin_o[15:0] ^ $past(wdata_i[15:0])) & ~$past(wdata_i[31:16]) & IMPL[15:0]) == '0));

  // R3
  hi_write_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == HI_A) |=>
      (((pin_o[31:16] ^ $past(wdata_i[15:0])) & ~$past(wdata_i[31:16]) & IMPL[31:16]) == '0));

  // R4
  lo_mask_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == LO_A) |=>
      (((pin_o[15:0] ^ $past(pin_o[15:0])) & $past(wdata_i[31:16])) == '0));

  // R4
  hi_mask_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == HI_A) |=>
      (((pin_o[31:16] ^ $past(pin_o[31:16])) & $past(wdata_i[31:16])) == '0));

  // R6
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DIR_A) |=> (dir_q == (($past(wdata_i) & IMPL) | FIXED)));

  // R7
  oe_needs_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~dir_q) == '0);

  // R8
  absent_bits_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o | pin_oe_o | rdata_o) & ~IMPL) == '0);

  // R9
  fixed_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q & FIXED) == FIXED);

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));

  // R11
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

bind gpio_bank gpio_bank_chk #(
  .BANK_IDX (BANK_IDX),
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .dir_q    (dir_q)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       pin_in0 = '0, pin_in1 = '0;
  logic [31:0]       rdata0, pin0, oe0, rdata1, pin1, oe1;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.BANK_IDX(0), .NUM_PINS(32), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0),
    .pin_i(pin_in0), .pin_o(pin0), .pin_oe_o(oe0));

  gpio_bank #(.BANK_IDX(1), .NUM_PINS(22), .ADDR_W(ADDR_W)) dut_b1_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1),
    .pin_i(pin_in1), .pin_o(pin1), .pin_oe_o(oe1));

  // {high_half, write word, expected bank-0 pin_o}
  localparam logic [64:0] VEC [7] = '{
    {1'b0, 32'h0000_00FF, 32'h0000_00FF},
    {1'b1, 32'h0000_A5A5, 32'hA5A5_00FF},
    {1'b0, 32'hFF00_1234, 32'hA5A5_0034},
    {1'b1, 32'hFFFE_0000, 32'hA5A4_0034},
    {1'b0, 32'hFFFF_FFFF, 32'hA5A4_0034},
    {1'b1, 32'h7FFF_0000, 32'h25A4_0034},
    {1'b0, 32'hFFFE_0001, 32'h25A4_0035}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] r0, output logic [31:0] r1);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    r0 = rdata0; r1 = rdata1;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1;
    logic [31:0] p0_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_o", pin0, 32'h0);
    check("R1 pin_oe_o", oe0, 32'h0);
    check("R1 rdata idle", rdata0, 32'h0);
    bus_rd(12'h204, r0, r1);
    check("R1 R9 dir reset bank0", r0, 32'h0000_0180);
    bus_rd(12'h244, r0, r1);
    check("R1 dir reset bank1", r1, 32'h0);

    // R2 R3 R4 vector table
    foreach (VEC[k]) begin
      bus_wr(VEC[k][64] ? 12'h004 : 12'h000, VEC[k][63:32]);
      check(VEC[k][64] ? "R3 R4 hi masked write" : "R2 R4 lo masked write", pin0, VEC[k][31:0]);
    end

    // R10 read latency and write-only / unmapped reads
    check("R10 idle after reads", rdata0, 32'h0);
    bus_rd(12'h000, r0, r1);
    check("R10 lo reg reads 0", r0, 32'h0);
    bus_rd(12'h004, r0, r1);
    check("R10 hi reg reads 0", r0, 32'h0);
    bus_rd(12'h3F0, r0, r1);
    check("R10 unmapped reads 0", r0, 32'h0);
    @(negedge clk);
    check("R10 rdata zero without strobe", rdata0, 32'h0);

    // R6 R9 direction
    bus_wr(12'h204, 32'h0000_0000);
    bus_rd(12'h204, r0, r1);
    check("R9 fixed dir bits stay 1", r0, 32'h0000_0180);
    bus_wr(12'h204, 32'hFFFF_0000);
    bus_rd(12'h204, r0, r1);
    check("R6 dir readback", r0, 32'hFFFF_0180);

    // R7 output enable
    bus_wr(12'h208, 32'h0000_FFFF);
    check("R7 oe needs dir", oe0, 32'h0000_0180);
    bus_rd(12'h208, r0, r1);
    check("R7 oen readback", r0, 32'h0000_FFFF);
    bus_wr(12'h204, 32'hFFFF_FFFF);
    check("R7 oe dir and oen", oe0, 32'h0000_FFFF);
    bus_wr(12'h208, 32'h0000_0000);
    check("R7 oe cleared", oe0, 32'h0);

    // R5 synchronizer latency
    pin_in0 = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_rd(12'h060, r0, r1);
    check("R5 level still old", r0, 32'h0);
    bus_rd(12'h060, r0, r1);
    check("R5 level new", r0, 32'hDEAD_BEEF);
    check("R5 pin_o unaffected by inputs", pin0, 32'h25A4_0035);

    // R8 R11 bank 1, 22 pins
    p0_before = pin0;
    bus_wr(12'h00C, 32'h0000_FFFF);
    check("R8 bank1 hi write clipped", pin1, 32'h003F_0000);
    check("R11 bank0 untouched by bank1 write", pin0, p0_before);
    bus_wr(12'h008, 32'h0000_FFFF);
    check("R8 bank1 lo write", pin1, 32'h003F_FFFF);
    bus_wr(12'h244, 32'hFFFF_FFFF);
    bus_rd(12'h244, r0, r1);
    check("R8 bank1 dir clipped", r1, 32'h003F_FFFF);
    check("R11 bank0 no read of bank1 reg", r0, 32'h0);
    bus_wr(12'h248, 32'hFFFF_FFFF);
    check("R8 bank1 oe clipped", oe1, 32'h003F_FFFF);
    pin_in1 = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    bus_rd(12'h064, r0, r1);
    check("R8 bank1 level clipped", r1, 32'h003F_FFFF);
    bus_rd(12'h204, r0, r1);
    check("R11 bank0 dir untouched", r0, 32'hFFFF_FFFF);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pin_o after reset", pin0, 32'h0);
    check("R1 oe after reset", oe1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule